// File: doc/BRIEF.md
# Configurable I/O Cell

This block is one configurable pad cell. It sits between the internal fabric and a single bidirectional pin. The output path carries a fabric data bit and a fabric enable to the pad driver. A static configuration bit picks whether the data bit reaches the pad straight from the fabric or through an output flip-flop. The input path returns the pad level to the fabric, again either straight through or through an input flip-flop. It always samples the pad, so the fabric can read back whatever the cell itself is driving.

The output flip-flop and the input flip-flop have separate clocks. A configuration bit for each selects rising-edge or falling-edge capture. A global set/reset line forces both flip-flops asynchronously. A per-register bit decides whether that line loads a 1 or a 0. Further configuration bits set the polarity of the fabric enable and select a weak pull-up, a weak pull-down or no pull. A slew bit is passed unchanged to the analog driver.

The pad itself is modelled in two-state logic. An external driver (`ext_drv`, `ext_val`), the cell's own driver and the weak pull are resolved inside the cell into a level (`pad_level`) and a flag that says whether that level is defined (`pad_known`). A floating pad or a fight between drivers is reported as unknown and never as an invented 0 or 1.

Top module: `pad_io_cell`

## Requirements
- R1: `pad_oe` equals `fab_oe` when `cfg_oe_low`=0 and its inverse when `cfg_oe_low`=1. While `pad_oe`=0 the pad level comes only from the external driver or the pull.
- R2: With `cfg_out_reg`=0, `pad_out` follows `fab_out` with no clock delay.
- R3: With `cfg_out_reg`=1, `pad_out` updates from `fab_out` only on the rising edge of `out_clk` when `cfg_out_clk_neg`=0, or only on its falling edge when `cfg_out_clk_neg`=1.
- R4: With `cfg_in_reg`=1, `fab_in` and `fab_in_known` update from the resolved pad only on the rising edge of `in_clk` when `cfg_in_clk_neg`=0, or only on its falling edge when `cfg_in_clk_neg`=1.
- R5: With `cfg_in_reg`=0, `fab_in` and `fab_in_known` follow the resolved pad directly. This includes readback of the cell's own driven value.
- R6: While `global_sr`=1, asynchronously and over any clock edge, the output register holds `cfg_out_gsr_set` and the input register holds `cfg_in_gsr_set` with its known flag set to 1.
- R7: `cfg_pull` encoding: 2'b01 is pull-down, 2'b10 is pull-up, 2'b00 and 2'b11 are no pull. When neither driver is active and a pull is enabled, the pad reads the pull value with `pad_known`=1. An active driver always overrides the pull.
- R8: When neither driver is active and no pull is enabled, `pad_known`=0. The input path then delivers `fab_in_known`=0.
- R9: When the cell and the external driver both drive, equal values give that value with `pad_known`=1, and different values give `pad_known`=0.
- R10: `pad_slow` equals `cfg_slew`. The slew bit has no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| out_clk | input | 1 | Output register clock |
| in_clk | input | 1 | Input register clock |
| global_sr | input | 1 | Asynchronous global set/reset, active high |
| cfg_out_reg | input | 1 | 1: output path registered |
| cfg_out_clk_neg | input | 1 | 1: output register uses falling edge |
| cfg_out_gsr_set | input | 1 | Value loaded into output register by global_sr |
| cfg_oe_low | input | 1 | 1: fab_oe is active low |
| cfg_in_reg | input | 1 | 1: input path registered |
| cfg_in_clk_neg | input | 1 | 1: input register uses falling edge |
| cfg_in_gsr_set | input | 1 | Value loaded into input register by global_sr |
| cfg_pull | input | 2 | Pull select (01 down, 10 up, else none) |
| cfg_slew | input | 1 | Slew setting, passed to the driver |
| fab_out | input | 1 | Data from fabric |
| fab_oe | input | 1 | Output enable from fabric |
| fab_in | output | 1 | Pad value to fabric |
| fab_in_known | output | 1 | fab_in holds a defined level |
| ext_drv | input | 1 | External driver on the pad is active |
| ext_val | input | 1 | External driver value |
| pad_out | output | 1 | Value the cell drives |
| pad_oe | output | 1 | Cell driver enabled |
| pad_level | output | 1 | Resolved pad level |
| pad_known | output | 1 | Resolved pad level is defined |
| pad_slow | output | 1 | Slew control to the analog driver |

## Verification
The bench sweeps all 1024 configuration combinations. After each data change it samples at instants between the four clock edges. A register on the wrong edge, or a direct path that is accidentally registered, would show an old or early value at one of those instants. It floats the pad with every pull setting. A cell that reads a floating pad as 0 would report a known value where unknown is expected. It forces contention with matching and opposing values. A cell that lets one driver silently win would report a known level during a fight. It also pulses the global set/reset with both load values. A register that ignored the per-register choice, or waited for a clock, would hold the wrong value while the line is high.

// File: rtl/pad_io_cell.sv
module pad_io_cell (
  input  logic       out_clk,
  input  logic       in_clk,
  input  logic       global_sr,
  input  logic       cfg_out_reg,
  input  logic       cfg_out_clk_neg,
  input  logic       cfg_out_gsr_set,
  input  logic       cfg_oe_low,
  input  logic       cfg_in_reg,
  input  logic       cfg_in_clk_neg,
  input  logic       cfg_in_gsr_set,
  input  logic [1:0] cfg_pull,
  input  logic       cfg_slew,
  input  logic       fab_out,
  input  logic       fab_oe,
  output logic       fab_in,
  output logic       fab_in_known,
  input  logic       ext_drv,
  input  logic       ext_val,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       pad_level,
  output logic       pad_known,
  output logic       pad_slow
);

  localparam logic [1:0] PULL_DN = 2'b01;
  localparam logic [1:0] PULL_UP = 2'b10;

  logic oclk, iclk;
  logic out_q, in_q, in_q_known;
  logic pull_up, pull_dn;

  assign oclk = out_clk ^ cfg_out_clk_neg;
  assign iclk = in_clk ^ cfg_in_clk_neg;
  assign pull_up = (cfg_pull == PULL_UP);
  assign pull_dn = (cfg_pull == PULL_DN);

  always_ff @(posedge oclk or posedge global_sr)
    if (global_sr) out_q <= cfg_out_gsr_set;
    else           out_q <= fab_out;

  assign pad_out  = cfg_out_reg ? out_q : fab_out;
  assign pad_oe   = fab_oe ^ cfg_oe_low;
  assign pad_slow = cfg_slew;

  always_comb begin
    pad_level = 1'b0;
    pad_known = 1'b0;
    if (pad_oe && ext_drv) begin
      pad_level = pad_out;
      pad_known = (pad_out == ext_val);
    end else if (pad_oe) begin
      pad_level = pad_out;
      pad_known = 1'b1;
    end else if (ext_drv) begin
      pad_level = ext_val;
      pad_known = 1'b1;
    end else if (pull_up || pull_dn) begin
      pad_level = pull_up;
      pad_known = 1'b1;
    end
  end

  always_ff @(posedge iclk or posedge global_sr)
    if (global_sr) begin
      in_q       <= cfg_in_gsr_set;
      in_q_known <= 1'b1;
    end else begin
      in_q       <= pad_level;
      in_q_known <= pad_known;
    end

  assign fab_in       = cfg_in_reg ? in_q : pad_level;
  assign fab_in_known = cfg_in_reg ? in_q_known : pad_known;

  a_r3_out_capture: assert property (@(posedge oclk) disable iff (global_sr)
    1'b1 |=> out_q == $past(fab_out));

  a_r4_in_capture: assert property (@(posedge iclk) disable iff (global_sr)
    1'b1 |=> {in_q, in_q_known} == $past({pad_level, pad_known}));

  a_r8_float_unknown: assert property (@(posedge out_clk) disable iff (global_sr)
    (!pad_oe && !ext_drv && cfg_pull != PULL_UP && cfg_pull != PULL_DN) |-> !pad_known);

  a_r7_pull_up_level: assert property (@(posedge out_clk) disable iff (global_sr)
    (!pad_oe && !ext_drv && cfg_pull == PULL_UP) |-> (pad_known && pad_level));

  a_r9_fight_unknown: assert property (@(posedge out_clk) disable iff (global_sr)
    (pad_oe && ext_drv && ext_val != pad_out) |-> !pad_known);

endmodule

// File: tb/tb_pad_io_cell.sv
`timescale 1ns/1ps
module tb_pad_io_cell;
  logic clk = 1'b0;
  logic in_clk = 1'b0;
  logic global_sr = 1'b1;
  logic cfg_out_reg = 1'b1, cfg_out_clk_neg = 1'b0, cfg_out_gsr_set = 1'b1, cfg_oe_low = 1'b0;
  logic cfg_in_reg = 1'b1, cfg_in_clk_neg = 1'b0, cfg_in_gsr_set = 1'b0, cfg_slew = 1'b0;
  logic [1:0] cfg_pull = 2'b00;
  logic fab_out = 1'b0, fab_oe = 1'b0, ext_drv = 1'b0, ext_val = 1'b0;
  logic fab_in, fab_in_known, pad_out, pad_oe, pad_level, pad_known, pad_slow;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) begin #5; in_clk = 1'b1; end
  always @(negedge clk) begin #5; in_clk = 1'b0; end

  pad_io_cell dut (
    .out_clk(clk), .in_clk(in_clk), .global_sr(global_sr),
    .cfg_out_reg(cfg_out_reg), .cfg_out_clk_neg(cfg_out_clk_neg), .cfg_out_gsr_set(cfg_out_gsr_set),
    .cfg_oe_low(cfg_oe_low), .cfg_in_reg(cfg_in_reg), .cfg_in_clk_neg(cfg_in_clk_neg),
    .cfg_in_gsr_set(cfg_in_gsr_set), .cfg_pull(cfg_pull), .cfg_slew(cfg_slew),
    .fab_out(fab_out), .fab_oe(fab_oe), .fab_in(fab_in), .fab_in_known(fab_in_known),
    .ext_drv(ext_drv), .ext_val(ext_val), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_level(pad_level), .pad_known(pad_known), .pad_slow(pad_slow));

  task automatic chk(input string tag, input logic act, input logic exp, input int cfg);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cfg=%0d actual=%b expected=%b t=%0t", tag, cfg, act, exp, $time);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #3;
    chk("R6 reset out", pad_out, 1'b1, -1);
    chk("R6 reset in", fab_in, 1'b0, -1);
    chk("R6 reset in known", fab_in_known, 1'b1, -1);
    for (int c = 0; c < 1024; c++) begin
      logic [9:0] v;
      logic act_oe, fl_known;
      v = c[9:0];
      @(posedge clk); #1;
      global_sr = 1'b1;
      cfg_out_reg = v[0]; cfg_out_clk_neg = v[1]; cfg_out_gsr_set = v[2]; cfg_oe_low = v[3];
      cfg_in_reg = v[4]; cfg_in_clk_neg = v[5]; cfg_in_gsr_set = v[6]; cfg_slew = v[7];
      cfg_pull = v[9:8];
      act_oe = ~v[3];
      fab_oe = ~act_oe; ext_drv = 1'b1; ext_val = 1'b0; fab_out = 1'b0;
      #2;
      chk("R10 slew pass", pad_slow, v[7], c);
      if (v[0]) chk("R6 out gsr", pad_out, v[2], c);
      if (v[4]) begin
        chk("R6 in gsr", fab_in, v[6], c);
        chk("R6 in gsr known", fab_in_known, 1'b1, c);
      end
      @(posedge clk); #1 global_sr = 1'b0;
      repeat (2) @(posedge clk);
      @(posedge clk); #1;
      fab_out = 1'b1; ext_val = 1'b1;
      #2;
      chk("R1 oe off", pad_oe, 1'b0, c);
      chk(v[0] ? "R3 out hold" : "R2 out direct", pad_out, !v[0], c);
      chk(v[4] ? "R4 in hold" : "R5 in direct", fab_in, !v[4], c);
      #4;
      chk(v[4] ? "R4 in rise" : "R5 in direct", fab_in, !v[4] || !v[5], c);
      #5;
      chk(v[0] ? "R3 out fall" : "R2 out direct", pad_out, !v[0] || v[1], c);
      #5;
      chk(v[4] ? "R4 in late" : "R5 in direct", fab_in, 1'b1, c);
      chk("R10 slew no effect", pad_level, 1'b1, c);
      #4;
      chk(v[0] ? "R3 out late" : "R2 out direct", pad_out, 1'b1, c);
      ext_drv = 1'b0;
      repeat (2) @(posedge clk);
      #3;
      fl_known = (v[9:8] == 2'b01) || (v[9:8] == 2'b10);
      chk(fl_known ? "R7 pull known" : "R8 float unknown", pad_known, fl_known, c);
      chk(fl_known ? "R7 pull fab known" : "R8 fab unknown", fab_in_known, fl_known, c);
      if (fl_known) begin
        chk("R7 pull level", pad_level, v[9:8] == 2'b10, c);
        chk("R7 pull fab", fab_in, v[9:8] == 2'b10, c);
      end
      for (int b = 0; b < 2; b++) begin
        fab_oe = act_oe; fab_out = b[0];
        repeat (2) @(posedge clk);
        #3;
        chk("R1 oe on", pad_oe, 1'b1, c);
        chk("R7 drive over pull", pad_level, b[0], c);
        chk("R5 readback", fab_in, b[0], c);
        chk("R5 readback known", fab_in_known, 1'b1, c);
        ext_drv = 1'b1; ext_val = ~b[0];
        repeat (2) @(posedge clk);
        #3;
        chk("R9 fight", pad_known, 1'b0, c);
        chk("R9 fight fab", fab_in_known, 1'b0, c);
        ext_val = b[0];
        repeat (2) @(posedge clk);
        #3;
        chk("R9 agree", pad_known, 1'b1, c);
        chk("R9 agree fab", fab_in, b[0], c);
        ext_drv = 1'b0;
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule